// File: doc/BRIEF.md
# Memory-Mapped Pin Bank

This block is a bank of general-purpose pins behind a small word-addressed register port. Software drives pins through an output latch and selects each pin's direction through a direction register. It samples pin levels through a two-stage synchronizer and reads them back from a data register. The bus port is single-cycle. A write takes effect at the clock edge on which `bus_we` is high. Read data is a combinational function of `bus_addr` and the current register contents.

Three elaboration parameters set the variant:

- **Output update style.** Either a write-one-to-set / write-one-to-clear register pair, or a single output register that replaces the whole latch on each write.
- **Direction register.** It can be absent, in which case every pin is permanently bidirectional. When present, a 1 can mean output, or a 1 can mean input.
- **Pin order.** Register bit n can map to pin n, or to pin WIDTH-1-n.

The register width is one of 8, 16, 32 or 64 bits, and there is one pin per bit. The word offsets are:

| Offset | Register |
|---|---|
| 0 | Data |
| 1 | Set / output |
| 2 | Clear |
| 3 | Direction |
| Any other offset | Unmapped |

Top module: `mmio_pin_bank`

## Requirements
- R1: While and after reset, the output latch is zero, so `pad_out` is all zeros. When a direction register exists, every pin is an input, so `pad_oe` is all zeros. The direction register then reads 0 with output polarity and all ones with input polarity.
- R2: A read at offset 0 returns the pin levels in register-bit order. A change on `pad_in` shows in that read only after two rising clock edges. Writes to offset 0 change nothing.
- R3: With set/clear enabled, a write at offset 1 raises every latch bit whose write-data bit is 1.
- R4: With set/clear enabled, a write at offset 2 lowers every latch bit whose write-data bit is 1. In both set and clear writes, bits written as 0 keep their latch value.
- R5: With set/clear disabled, a write at offset 1 loads the whole latch with the write data, and writes at offset 2 change nothing.
- R6: A read at offset 1 returns the current output latch in register-bit order.
- R7: Reads at offset 2 and at any offset of 4 or above return zero.
- R8: With a direction register, a write at offset 3 stores the write data, and a read at offset 3 returns it. With output polarity, `pad_oe` for a pin is the stored bit. With input polarity, `pad_oe` is the inverted stored bit.
- R9: With no direction register, `pad_oe` is all ones at all times, writes at offset 3 change nothing, and reads at offset 3 return zero.
- R10: With reversed numbering, pin n corresponds to register bit WIDTH-1-n for `pad_out`, `pad_oe` and the data read. Otherwise pin n corresponds to register bit n.
- R11: `pad_out` holds the mapped output latch and changes only on writes to offset 1 or 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | WIDTH | Write data in register-bit order |
| bus_rdata | output | WIDTH | Read data for `bus_addr`, combinational |
| pad_out | output | WIDTH | Value driven on each pin |
| pad_oe | output | WIDTH | Output enable for each pin |
| pad_in | input | WIDTH | Pin levels from the pads, asynchronous |

## Verification
The hardest case to reach from the ports is the synchronizer latency. To see it, the data read must be taken exactly one edge after a pin change, when the read must still show the old value, and again two edges after the change. The bench provokes this by changing `pad_in` on a falling edge and reading offset 0 on each of the next falling edges. Three instances run side by side on the same bus stimulus: set/clear with output polarity, single register with input polarity and reversed pins, and set/clear with no direction register. A single random access stream therefore covers every variant and both bit orders.

// File: rtl/mmio_pin_pkg.sv
package mmio_pin_pkg;

  typedef enum logic [1:0] {
    DIR_NONE     = 2'd0,
    DIR_OUT_HIGH = 2'd1,
    DIR_IN_HIGH  = 2'd2
  } dir_mode_e;

  localparam int unsigned OFS_DATA = 0;
  localparam int unsigned OFS_SET  = 1;
  localparam int unsigned OFS_CLR  = 2;
  localparam int unsigned OFS_DIR  = 3;

endpackage

// File: rtl/mmio_pin_sync.sv
module mmio_pin_sync #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/mmio_pin_latch.sv
module mmio_pin_latch #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          SETCLR_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] latch_q
);

  logic [WIDTH-1:0] latch_d;
  logic             latch_en;

  generate
    if (SETCLR_EN) begin : g_setclr
      always_comb begin
        latch_d = latch_q;
        if (wr_set) latch_d = latch_d | wdata;
        if (wr_clr) latch_d = latch_d & ~wdata;
      end
      assign latch_en = wr_set | wr_clr;
    end else begin : g_single
      always_comb begin
        latch_d = wdata;
      end
      assign latch_en = wr_set;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= '0;
    end else if (latch_en) begin
      latch_q <= latch_d;
    end
  end

endmodule

// File: rtl/mmio_pin_dir.sv
module mmio_pin_dir #(
  parameter int unsigned             WIDTH    = 32,
  parameter mmio_pin_pkg::dir_mode_e DIR_MODE = mmio_pin_pkg::DIR_OUT_HIGH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] oe_reg
);

  generate
    if (DIR_MODE == mmio_pin_pkg::DIR_NONE) begin : g_bidir
      assign dir_q  = '0;
      assign oe_reg = '1;
    end else begin : g_reg
      localparam logic [WIDTH-1:0] RST_VAL =
        (DIR_MODE == mmio_pin_pkg::DIR_IN_HIGH) ? '1 : '0;
      logic [WIDTH-1:0] dir_r;
      logic [WIDTH-1:0] dir_d;

      always_comb begin
        dir_d = wdata;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dir_r <= RST_VAL;
        end else if (wr_dir) begin
          dir_r <= dir_d;
        end
      end

      assign dir_q = dir_r;
      if (DIR_MODE == mmio_pin_pkg::DIR_IN_HIGH) begin : g_inv
        assign oe_reg = ~dir_r;
      end else begin : g_pass
        assign oe_reg = dir_r;
      end
    end
  endgenerate

endmodule

// File: rtl/mmio_pin_swizzle.sv
module mmio_pin_swizzle #(
  parameter int unsigned WIDTH   = 32,
  parameter bit          REVERSE = 1'b0
) (
  input  logic [WIDTH-1:0] vec_in,
  output logic [WIDTH-1:0] vec_out
);

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (REVERSE) begin : g_rev
        assign vec_out[i] = vec_in[WIDTH-1-i];
      end else begin : g_fwd
        assign vec_out[i] = vec_in[i];
      end
    end
  endgenerate

endmodule

// File: rtl/mmio_pin_bank.sv
module mmio_pin_bank #(
  parameter int unsigned             WIDTH       = 32,
  parameter int unsigned             ADDR_W      = 3,
  parameter bit                      SETCLR_EN   = 1'b1,
  parameter mmio_pin_pkg::dir_mode_e DIR_MODE    = mmio_pin_pkg::DIR_OUT_HIGH,
  parameter bit                      BIT_REVERSE = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(mmio_pin_pkg::OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(mmio_pin_pkg::OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(mmio_pin_pkg::OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(mmio_pin_pkg::OFS_DIR);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             wr_set;
  logic             wr_clr;
  logic             wr_dir;
  logic [WIDTH-1:0] latch_q;
  logic [WIDTH-1:0] dir_q;
  logic [WIDTH-1:0] oe_reg;
  logic [WIDTH-1:0] pins_sync;
  logic [WIDTH-1:0] pins_reg;

  // Reset asserts at once and releases two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  always_comb begin
    wr_set = bus_we && (bus_addr == A_SET);
    wr_clr = bus_we && (bus_addr == A_CLR);
    wr_dir = bus_we && (bus_addr == A_DIR);
  end

  mmio_pin_latch #(.WIDTH(WIDTH), .SETCLR_EN(SETCLR_EN)) latch_i (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_set  (wr_set),
    .wr_clr  (wr_clr),
    .wdata   (bus_wdata),
    .latch_q (latch_q)
  );

  mmio_pin_dir #(.WIDTH(WIDTH), .DIR_MODE(DIR_MODE)) dir_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_dir (wr_dir),
    .wdata  (bus_wdata),
    .dir_q  (dir_q),
    .oe_reg (oe_reg)
  );

  mmio_pin_sync #(.WIDTH(WIDTH)) sync_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .async_in (pad_in),
    .sync_out (pins_sync)
  );

  mmio_pin_swizzle #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) swz_out_i (
    .vec_in  (latch_q),
    .vec_out (pad_out)
  );

  mmio_pin_swizzle #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) swz_oe_i (
    .vec_in  (oe_reg),
    .vec_out (pad_oe)
  );

  mmio_pin_swizzle #(.WIDTH(WIDTH), .REVERSE(BIT_REVERSE)) swz_in_i (
    .vec_in  (pins_sync),
    .vec_out (pins_reg)
  );

  always_comb begin
    if (bus_addr == A_DATA) begin
      bus_rdata = pins_reg;
    end else if (bus_addr == A_SET) begin
      bus_rdata = latch_q;
    end else if (bus_addr == A_DIR) begin
      bus_rdata = dir_q;
    end else begin
      bus_rdata = '0;
    end
  end

endmodule

// File: rtl/mmio_pin_bank_chk.sv
module mmio_pin_bank_chk #(
  parameter int unsigned             WIDTH       = 32,
  parameter int unsigned             ADDR_W      = 3,
  parameter bit                      SETCLR_EN   = 1'b1,
  parameter mmio_pin_pkg::dir_mode_e DIR_MODE    = mmio_pin_pkg::DIR_OUT_HIGH,
  parameter bit                      BIT_REVERSE = 1'b0
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  pad_in
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(mmio_pin_pkg::OFS_DATA);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(mmio_pin_pkg::OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(mmio_pin_pkg::OFS_CLR);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(mmio_pin_pkg::OFS_DIR);
  localparam bit HAS_DIR = (DIR_MODE != mmio_pin_pkg::DIR_NONE);

  function automatic logic [WIDTH-1:0] to_reg(input logic [WIDTH-1:0] v);
    logic [WIDTH-1:0] r;
    for (int i = 0; i < WIDTH; i++) begin
      r[i] = BIT_REVERSE ? v[WIDTH-1-i] : v[i];
    end
    return r;
  endfunction

  logic [WIDTH-1:0] out_reg;
  logic [1:0]       cyc_q;

  always_comb begin
    out_reg = to_reg(pad_out);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cyc_q <= 2'd0;
    end else if (cyc_q != 2'd3) begin
      cyc_q <= cyc_q + 2'd1;
    end
  end

  assert_sync_data_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cyc_q >= 2'd2 && bus_addr == A_DATA) |-> bus_rdata == to_reg($past(pad_in, 2)));

  assert_set_bits_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (SETCLR_EN && bus_we && bus_addr == A_SET)
      |=> (out_reg & $past(bus_wdata)) == $past(bus_wdata));

  assert_clear_bits_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (SETCLR_EN && bus_we && bus_addr == A_CLR) |=> (out_reg & $past(bus_wdata)) == '0);

  assert_replace_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!SETCLR_EN && bus_we && bus_addr == A_SET) |=> out_reg == $past(bus_wdata));

  assert_clr_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_addr == A_CLR) |-> bus_rdata == '0);

  assert_oe_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (HAS_DIR && !(bus_we && bus_addr == A_DIR)) |=> $stable(pad_oe));

  assert_bidir_oe_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !HAS_DIR |-> pad_oe == '1);

  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we && (bus_addr == A_SET || bus_addr == A_CLR)) |=> $stable(pad_out));

endmodule

bind mmio_pin_bank mmio_pin_bank_chk #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .SETCLR_EN(SETCLR_EN),
  .DIR_MODE(DIR_MODE), .BIT_REVERSE(BIT_REVERSE)
) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pad_out    (pad_out),
  .pad_oe     (pad_oe),
  .pad_in     (pad_in)
);

// File: tb/mmio_pin_bank_tb_top.sv
`timescale 1ns/1ps
module mmio_pin_bank_tb_top;

  localparam int W  = 32;
  localparam int AW = 3;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_we;
  logic [W-1:0]  bus_wdata;
  logic [W-1:0]  pad_in;
  logic [W-1:0]  rdata [3];
  logic [W-1:0]  pout  [3];
  logic [W-1:0]  poe   [3];

  int nchk;
  int nfail;
  logic [W-1:0] m_lat [3];
  logic [W-1:0] m_dir [3];
  logic [W-1:0] cur_pins;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Variant 0: set/clear, output polarity, straight numbering.
  mmio_pin_bank #(.WIDTH(W), .ADDR_W(AW), .SETCLR_EN(1'b1),
    .DIR_MODE(mmio_pin_pkg::DIR_OUT_HIGH), .BIT_REVERSE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[0]), .pad_out(pout[0]),
    .pad_oe(poe[0]), .pad_in(pad_in));

  // Variant 1: single register, input polarity, reversed numbering.
  mmio_pin_bank #(.WIDTH(W), .ADDR_W(AW), .SETCLR_EN(1'b0),
    .DIR_MODE(mmio_pin_pkg::DIR_IN_HIGH), .BIT_REVERSE(1'b1)) dut_b (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[1]), .pad_out(pout[1]),
    .pad_oe(poe[1]), .pad_in(pad_in));

  // Variant 2: set/clear, no direction register.
  mmio_pin_bank #(.WIDTH(W), .ADDR_W(AW), .SETCLR_EN(1'b1),
    .DIR_MODE(mmio_pin_pkg::DIR_NONE), .BIT_REVERSE(1'b0)) dut_c (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(rdata[2]), .pad_out(pout[2]),
    .pad_oe(poe[2]), .pad_in(pad_in));

  function automatic bit cfg_sc(input int k);  return k != 1; endfunction
  function automatic bit cfg_rev(input int k); return k == 1; endfunction
  function automatic int cfg_dir(input int k); return (k == 0) ? 1 : ((k == 1) ? 2 : 0); endfunction

  function automatic logic [W-1:0] rev32(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[W-1-i];
    return r;
  endfunction

  function automatic logic [W-1:0] pinmap(input int k, input logic [W-1:0] v);
    return cfg_rev(k) ? rev32(v) : v;
  endfunction

  function automatic logic [W-1:0] exp_oe(input int k);
    logic [W-1:0] o;
    case (cfg_dir(k))
      1:       o = m_dir[k];
      2:       o = ~m_dir[k];
      default: o = '1;
    endcase
    return pinmap(k, o);
  endfunction

  function automatic logic [W-1:0] exp_read(input int k, input logic [AW-1:0] a);
    case (a)
      3'd0:    return pinmap(k, cur_pins);
      3'd1:    return m_lat[k];
      3'd3:    return (cfg_dir(k) == 0) ? '0 : m_dir[k];
      default: return '0;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    for (int k = 0; k < 3; k++) begin
      if (a == 3'd1) m_lat[k] = cfg_sc(k) ? (m_lat[k] | d) : d;
      else if (a == 3'd2 && cfg_sc(k)) m_lat[k] = m_lat[k] & ~d;
      else if (a == 3'd3 && cfg_dir(k) != 0) m_lat[k] = m_lat[k];
      if (a == 3'd3 && cfg_dir(k) != 0) m_dir[k] = d;
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    model_write(a, d);
  endtask

  // R11 R10 R8 R9: pads against the model.
  task automatic check_pads(input string tag);
    for (int k = 0; k < 3; k++) begin
      check($sformatf("R11 pad_out %s dut%0d", tag, k), pout[k], pinmap(k, m_lat[k]));
      check($sformatf("R8 pad_oe %s dut%0d", tag, k), poe[k], exp_oe(k));
    end
  endtask

  task automatic read_all(input logic [AW-1:0] a, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    for (int k = 0; k < 3; k++)
      check($sformatf("%s off%0d dut%0d", tag, a, k), rdata[k], exp_read(k, a));
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
  end

  initial begin
    nchk = 0; nfail = 0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; pad_in = '0; cur_pins = '0;
    m_lat[0] = '0; m_lat[1] = '0; m_lat[2] = '0;
    m_dir[0] = '0; m_dir[1] = '1; m_dir[2] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_pads("R1 reset");
    read_all(3'd3, "R1 dir reset");
    read_all(3'd1, "R1 latch reset");

    // R3 / R5: set or replace
    bus_write(3'd1, 32'h0000_00F0);
    check_pads("R3 R5 set");
    read_all(3'd1, "R6 readback");
    bus_write(3'd1, 32'h0000_0003);
    check_pads("R3 R5 accumulate");
    // R4 clear, ignored in single mode (R5)
    bus_write(3'd2, 32'h0000_0030);
    check_pads("R4 clear");
    bus_write(3'd1, 32'h0000_0000);
    check_pads("R3 zero write");
    read_all(3'd1, "R6 readback");
    // R2 writes to data ignored
    bus_write(3'd0, 32'hFFFF_FFFF);
    check_pads("R2 data write ignored");
    // R7 clear and unmapped reads
    read_all(3'd2, "R7");
    read_all(3'd4, "R7");
    read_all(3'd7, "R7");
    // R8 R9 direction
    bus_write(3'd3, 32'h0F0F_00FF);
    check_pads("R8 R9 dir");
    read_all(3'd3, "R8 R9 dir read");

    // R2 R10 synchronizer latency
    @(negedge clk);
    pad_in = 32'h8000_0001;
    @(negedge clk);
    bus_addr = 3'd0; #1;
    for (int k = 0; k < 3; k++)
      check($sformatf("R2 one-edge old value dut%0d", k), rdata[k], pinmap(k, cur_pins));
    @(negedge clk);
    cur_pins = pad_in;
    bus_addr = 3'd0; #1;
    for (int k = 0; k < 3; k++)
      check($sformatf("R2 R10 two-edge value dut%0d", k), rdata[k], pinmap(k, cur_pins));

    // Random mix
    for (int it = 0; it < 400; it++) begin
      logic [AW-1:0] a;
      logic [W-1:0]  d;
      a = AW'($urandom_range(0, 7));
      if (a > 3'd3 && ($urandom_range(0, 3) != 0)) a = AW'($urandom_range(1, 3));
      d = $urandom();
      @(negedge clk);
      pad_in = $urandom();
      bus_write(a, d);
      check_pads("rand R3 R4 R5");
      cur_pins = pad_in;
      read_all(AW'($urandom_range(0, 7)), "rand R2 R6 R7 R8 R10");
    end

    report();
  end

endmodule